// File: doc/BRIEF.md
# Miss-Stride Recurrence Prefetcher

This block sits on the miss path between a first-level data cache and the second-level cache. It watches the stream of first-level misses and looks for lines that keep missing at a regular distance, where that distance is counted in misses and not in cycles. A typical case is a conflict miss on data that is reused on every pass of a loop. Each miss also advances a global miss counter. A small table remembers recently missed lines and the counter value at which each one last missed. When a tracked line misses again, the number of other misses since its previous miss is the gap. Once the same gap has been seen twice in a row, the block predicts that the line will miss again after that many further misses. It then requests a prefetch of that same line a fixed lead of misses ahead of time.

Issued prefetches are recorded as tags in a small prefetch buffer. Every incoming miss is also looked up in that buffer. One cycle later the block reports whether the line had already been prefetched, so the second-level request can be skipped. A hit consumes the buffer entry. The block only tracks tags. Fetching the data, and replacement inside the first-level cache, are outside it.

Top module: `miss_recur_pf`

## Requirements
- R1: After reset, `pf_valid` and `pb_hit` are low, the tracking table is empty and the miss counter is zero.
- R2: Each cycle with `miss_valid` high counts one miss. The gap of a tracked line is the number of other misses between two of its misses. For an armed line with gap N whose latest miss left the counter at S+1, one prefetch of that same line is issued once the counter reaches S+N+1-LEAD (LEAD defaults to 1). `pf_valid` pulses for one cycle, two clock edges after the miss that triggers it.
- R3: A line arms only when two consecutive re-misses show the same gap. The first gap observed issues no prefetch.
- R4: A re-miss whose gap differs from the learned gap disarms the line and relearns the new gap. No further prefetch of it is issued until that new gap is seen again.
- R5: A gap smaller than LEAD never arms a line. With the default lead, back-to-back misses to one line (gap 0) never cause a prefetch.
- R6: When the repeated gap equals LEAD, the prefetch is issued straight after the arming miss itself.
- R7: `pb_hit` is high in the cycle after a miss whose line is held in the prefetch buffer. That entry is then removed, so the next miss to the line reports no hit unless the line was prefetched again. A miss to a line never prefetched gives no hit.
- R8: The table tracks TRK_N lines (default 8) and replaces them in allocation order. A set of 8 lines missed in rotation gets prefetched. A rotation of 9 lines never does, because each line is evicted before it returns.
- R9: The 16-bit miss counter wraps, and gap computation and issue timing stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A first-level miss occurs this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| pf_valid | output | 1 | Prefetch request toward the second-level cache |
| pf_line | output | LINE_W | Line address to prefetch |
| pb_hit | output | 1 | The miss of the previous cycle hit in the prefetch buffer |

## Verification
The bench drives recurring miss patterns and looks for the exact miss after which a prefetch appears. A design that issues on the first observed gap fires several misses too early. A design with an off-by-one in the gap or in the lead fires one step early or late. A design that keeps an entry armed after its gap changes keeps prefetching a line that is no longer recurring.

The bench also covers these corner cases:
- Gap zero and gap equal to the lead: getting these wrong either floods requests or drops the immediate issue.
- A rotation of exactly the table depth, and one line beyond it: this exposes an off-by-one in FIFO replacement.
- A trained pattern placed across the counter wrap: this exposes unsigned compares that would lose the prefetch there.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    localparam int unsigned DEF_LINE_W = 20;
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_TRK_N  = 8;
    localparam int unsigned DEF_PB_N   = 4;
    localparam int unsigned DEF_LEAD   = 1;
endpackage

// File: rtl/mrp_miss_counter.sv
module mrp_miss_counter #(
    parameter int unsigned CNT_W = mrp_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (miss_valid) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> $stable(cnt_q));
endmodule

// File: rtl/mrp_track_table.sv
module mrp_track_table #(
    parameter int unsigned LINE_W = mrp_pkg::DEF_LINE_W,
    parameter int unsigned CNT_W  = mrp_pkg::DEF_CNT_W,
    parameter int unsigned TRK_N  = mrp_pkg::DEF_TRK_N,
    parameter int unsigned LEAD   = mrp_pkg::DEF_LEAD
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         miss_valid,
    input  logic [LINE_W-1:0]            miss_line,
    input  logic [CNT_W-1:0]             cnt_q,
    input  logic [TRK_N-1:0]             grant,
    output logic [TRK_N-1:0]             pend,
    output logic [TRK_N-1:0][LINE_W-1:0] lines
);
    localparam int unsigned TRK_IW = (TRK_N > 1) ? $clog2(TRK_N) : 1;
    localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] addr;
        logic [CNT_W-1:0]  stamp;
        logic [CNT_W-1:0]  gap;
        logic              has_gap;
        logic              armed;
    } trk_ent_t;

    typedef struct packed {
        trk_ent_t [TRK_N-1:0] ent;
        logic [TRK_N-1:0]     pend;
        logic [TRK_IW-1:0]    wptr;
    } trk_st_t;

    trk_st_t st_q, st_d;

    logic [TRK_N-1:0]  hit_vec;
    logic              hit_any;
    logic [TRK_IW-1:0] hit_idx;
    logic [CNT_W-1:0]  new_gap;
    logic [CNT_W-1:0]  cnt_next;

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = TRK_N - 1; i >= 0; i--) begin
            hit_vec[i] = st_q.ent[i].vld && (st_q.ent[i].addr == miss_line);
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = TRK_IW'(i);
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.pend = st_q.pend & ~grant;
        cnt_next = cnt_q + ONE_C;
        new_gap  = cnt_q - st_q.ent[hit_idx].stamp - ONE_C;

        if (miss_valid) begin
            if (hit_any) begin
                if (st_q.ent[hit_idx].has_gap && (new_gap == st_q.ent[hit_idx].gap)) begin
                    st_d.ent[hit_idx].armed = (new_gap >= LEAD_C);
                end else begin
                    st_d.ent[hit_idx].gap     = new_gap;
                    st_d.ent[hit_idx].has_gap = 1'b1;
                    st_d.ent[hit_idx].armed   = 1'b0;
                end
                st_d.ent[hit_idx].stamp = cnt_q;
            end else begin
                st_d.ent[st_q.wptr].vld     = 1'b1;
                st_d.ent[st_q.wptr].addr    = miss_line;
                st_d.ent[st_q.wptr].stamp   = cnt_q;
                st_d.ent[st_q.wptr].gap     = '0;
                st_d.ent[st_q.wptr].has_gap = 1'b0;
                st_d.ent[st_q.wptr].armed   = 1'b0;
                st_d.pend[st_q.wptr]        = 1'b0;
                if (st_q.wptr == TRK_IW'(TRK_N - 1)) st_d.wptr = '0;
                else                                 st_d.wptr = st_q.wptr + TRK_IW'(1);
            end
            for (int i = 0; i < TRK_N; i++) begin
                if (st_d.ent[i].armed &&
                    (cnt_next == st_d.ent[i].stamp + st_d.ent[i].gap + ONE_C - LEAD_C))
                    st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pend = st_q.pend;
        for (int i = 0; i < TRK_N; i++) lines[i] = st_q.ent[i].addr;
    end

    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.pend == '0) && (st_q.wptr == '0));
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    for (genvar g = 0; g < TRK_N; g++) begin : g_chk
        assert_arm_needs_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ent[g].armed |-> (st_q.ent[g].gap >= LEAD_C) && st_q.ent[g].has_gap);
        assert_arm_needs_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.ent[g].armed) |-> $past(st_q.ent[g].has_gap));
    end
endmodule

// File: rtl/mrp_issue_arb.sv
module mrp_issue_arb #(
    parameter int unsigned LINE_W = mrp_pkg::DEF_LINE_W,
    parameter int unsigned TRK_N  = mrp_pkg::DEF_TRK_N
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [TRK_N-1:0]             pend,
    input  logic [TRK_N-1:0][LINE_W-1:0] lines,
    output logic [TRK_N-1:0]             grant,
    output logic                         pf_valid,
    output logic [LINE_W-1:0]            pf_line
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
    } arb_st_t;

    arb_st_t st_q, st_d;

    always_comb begin
        grant = '0;
        st_d  = '{vld: 1'b0, line: st_q.line};
        for (int i = TRK_N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                st_d.vld  = 1'b1;
                st_d.line = lines[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pf_valid = st_q.vld;
    assign pf_line  = st_q.line;

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_pf_from_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(pend != '0));
endmodule

// File: rtl/mrp_pf_buffer.sv
module mrp_pf_buffer #(
    parameter int unsigned LINE_W = mrp_pkg::DEF_LINE_W,
    parameter int unsigned PB_N   = mrp_pkg::DEF_PB_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              lk_en,
    input  logic [LINE_W-1:0] lk_line,
    output logic              hit
);
    localparam int unsigned PB_IW = (PB_N > 1) ? $clog2(PB_N) : 1;

    typedef struct packed {
        logic [PB_N-1:0]             vld;
        logic [PB_N-1:0][LINE_W-1:0] tag;
        logic [PB_IW-1:0]            wptr;
        logic                        hit;
    } pb_st_t;

    pb_st_t st_q, st_d;
    logic   dup;

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        dup      = 1'b0;
        for (int i = 0; i < PB_N; i++) begin
            if (st_q.vld[i] && (st_q.tag[i] == wr_line)) dup = 1'b1;
            if (lk_en && st_q.vld[i] && (st_q.tag[i] == lk_line)) begin
                st_d.hit    = 1'b1;
                st_d.vld[i] = 1'b0;
            end
        end
        if (wr_en && !dup) begin
            st_d.vld[st_q.wptr] = 1'b1;
            st_d.tag[st_q.wptr] = wr_line;
            if (st_q.wptr == PB_IW'(PB_N - 1)) st_d.wptr = '0;
            else                               st_d.wptr = st_q.wptr + PB_IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.hit;

    assert_hit_follows_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(lk_en));
    assert_no_hit_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !hit);
endmodule

// File: rtl/miss_recur_pf.sv
module miss_recur_pf #(
    parameter int unsigned LINE_W = mrp_pkg::DEF_LINE_W,
    parameter int unsigned CNT_W  = mrp_pkg::DEF_CNT_W,
    parameter int unsigned TRK_N  = mrp_pkg::DEF_TRK_N,
    parameter int unsigned PB_N   = mrp_pkg::DEF_PB_N,
    parameter int unsigned LEAD   = mrp_pkg::DEF_LEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              pb_hit
);
    logic [CNT_W-1:0]             cnt_q;
    logic [TRK_N-1:0]             pend;
    logic [TRK_N-1:0]             grant;
    logic [TRK_N-1:0][LINE_W-1:0] lines;

    mrp_miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .cnt_q(cnt_q)
    );

    mrp_track_table #(.LINE_W(LINE_W), .CNT_W(CNT_W), .TRK_N(TRK_N), .LEAD(LEAD)) u_trk (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .cnt_q(cnt_q), .grant(grant), .pend(pend), .lines(lines)
    );

    mrp_issue_arb #(.LINE_W(LINE_W), .TRK_N(TRK_N)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend), .lines(lines), .grant(grant),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    mrp_pf_buffer #(.LINE_W(LINE_W), .PB_N(PB_N)) u_pb (
        .clk(clk), .rst_n(rst_n), .wr_en(pf_valid), .wr_line(pf_line),
        .lk_en(miss_valid), .lk_line(miss_line), .hit(pb_hit)
    );

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);
endmodule

// File: tb/miss_recur_pf_bench.sv
module miss_recur_pf_bench;
    localparam int LW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [LW-1:0] miss_line = '0;
    logic          pf_valid;
    logic [LW-1:0] pf_line;
    logic          pb_hit;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    bit            got_pf;
    logic [LW-1:0] got_pfl;
    bit            got_hit;

    always #10 clk = ~clk;

    miss_recur_pf u_miss_recur_pf (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_line(miss_line),
        .pf_valid(pf_valid), .pf_line(pf_line), .pb_hit(pb_hit)
    );

    localparam logic [LW-1:0] LA  = 20'h0A000, LB1 = 20'h0B001, LB2 = 20'h0B002;
    localparam logic [LW-1:0] LC1 = 20'h0C001, LC2 = 20'h0C002;
    localparam logic [LW-1:0] LD1 = 20'h0D001, LD2 = 20'h0D002, LZ = 20'h0;
    // vector: miss line, expect prefetch, expected prefetch line, expect buffer hit
    localparam int NV = 19;
    localparam logic [41:0] VEC [NV] = '{
        {LA, 1'b0, LZ, 1'b0}, {LB1, 1'b0, LZ, 1'b0}, {LB2, 1'b0, LZ, 1'b0},
        {LA, 1'b0, LZ, 1'b0}, {LC1, 1'b0, LZ, 1'b0}, {LC2, 1'b0, LZ, 1'b0},
        {LA, 1'b0, LZ, 1'b0}, {LD1, 1'b1, LA, 1'b0}, {LD2, 1'b0, LZ, 1'b0},
        {LA, 1'b0, LZ, 1'b1}, {LB1, 1'b1, LA, 1'b0}, {LB2, 1'b0, LZ, 1'b0},
        {LA, 1'b0, LZ, 1'b1}, {LC1, 1'b1, LA, 1'b0}, {LA, 1'b0, LZ, 1'b1},
        {LB1, 1'b0, LZ, 1'b0}, {LB2, 1'b0, LZ, 1'b0}, {LC1, 1'b0, LZ, 1'b0},
        {LA, 1'b0, LZ, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        if (pf_valid) begin got_pf = 1'b1; got_pfl = pf_line; end
        if (pb_hit) got_hit = 1'b1;
    endtask

    task automatic step(input logic [LW-1:0] line);
        got_pf = 1'b0; got_pfl = '0; got_hit = 1'b0;
        @(negedge clk);
        miss_valid = 1'b1; miss_line = line;
        @(negedge clk);
        miss_valid = 1'b0;
        sample();
        repeat (2) begin
            @(negedge clk);
            sample();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; miss_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic logic [LW-1:0] gline(input int i);
        return 20'h10000 + LW'(i);
    endfunction

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(!pf_valid, "R1 pf_valid after reset", 32'(pf_valid), 0);
        chk(!pb_hit, "R1 pb_hit after reset", 32'(pb_hit), 0);

        // table walk: R2 issue timing, R3 repeat needed, R4 retrain, R7 buffer hits
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][41:22]);
            chk(got_pf == VEC[v][21], $sformatf("R2/R3/R4 prefetch at step %0d", v), 32'(got_pf), 32'(VEC[v][21]));
            if (VEC[v][21])
                chk(got_pfl == VEC[v][20:1], $sformatf("R2 prefetch line at step %0d", v), 32'(got_pfl), 32'(VEC[v][20:1]));
            chk(got_hit == VEC[v][0], $sformatf("R7 buffer hit at step %0d", v), 32'(got_hit), 32'(VEC[v][0]));
        end

        // R5: gap zero never arms
        do_reset();
        for (int k = 0; k < 5; k++) begin
            step(LA);
            chk(!got_pf, "R5 gap zero no prefetch", 32'(got_pf), 0);
        end

        // R6: gap equal to lead issues right after arming miss
        do_reset();
        for (int k = 0; k < 5; k++) begin
            step((k % 2 == 0) ? LA : LB1);
            if (k < 4) chk(!got_pf, "R6 no prefetch before arming", 32'(got_pf), 0);
            else chk(got_pf && got_pfl == LA, "R6 immediate prefetch", 32'(got_pfl), 32'(LA));
        end

        // R8: rotation of 8 lines fits the table
        do_reset();
        for (int k = 0; k < 23; k++) begin
            step(gline(k % 8));
            if (k < 22) chk(!got_pf, "R8 no early prefetch in 8-rotation", 32'(got_pf), 0);
            else chk(got_pf && got_pfl == gline(0), "R8 8-rotation prefetch", 32'(got_pfl), 32'(gline(0)));
        end

        // R8: rotation of 9 lines thrashes the table
        do_reset();
        begin
            int seen = 0;
            for (int k = 0; k < 28; k++) begin
                step(gline(k % 9));
                if (got_pf) seen++;
            end
            chk(seen == 0, "R8 9-rotation never prefetches", 32'(seen), 0);
        end

        // R9: trained pattern across the counter wrap
        do_reset();
        @(negedge clk);
        miss_valid = 1'b1; miss_line = LD2;
        repeat (65530) @(negedge clk);
        miss_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step((k % 3 == 0) ? LA : ((k % 3 == 1) ? LB1 : LB2));
            if (k < 7) chk(!got_pf, "R9 no prefetch before wrap issue", 32'(got_pf), 0);
            else chk(got_pf && got_pfl == LA, "R9 prefetch across wrap", 32'(got_pfl), 32'(LA));
        end

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule